// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits inside an asynchronous DRAM controller and decides when refresh cycles have to run. After reset it holds off all activity for a start-up delay. It then asks the RAS/CAS sequencer for a burst of initialization refreshes. Once that burst has been granted, it raises periodic refresh requests often enough that every row is covered within the retention period.

Each periodic interval adds one refresh to a saturating owed count, and each grant from the sequencer takes one away. When the count is full, an urgent flag tells the sequencer to give refresh priority over host traffic. A mode input selects the refresh kind. In CAS-before-RAS mode the device uses its internal row counter, so the block drives a zero row. In RAS-only mode the block supplies a row from its own counter, which advances on every granted refresh. Host requests are refused until initialization has finished.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset is released, `ref_req_o` and `init_done_o` stay low for exactly STARTUP_US*CLK_MHZ clock edges. `ref_req_o` first reads high after edge number STARTUP_US*CLK_MHZ.
- R2: During initialization, `ref_req_o` stays high until INIT_REFS (default 8) grants have been accepted. `init_done_o` rises at the edge that accepts the last of them and stays high until reset.
- R3: `host_gnt_o` is high exactly when `host_req_i` is high and `init_done_o` is high.
- R4: After initialization, the owed count rises by one every RETENTION_US*CLK_MHZ/ROWS cycles. The first increment happens that many edges after `init_done_o` rises.
- R5: An accepted grant lowers the owed count by one. An interval tick and an accepted grant in the same cycle leave the count unchanged.
- R6: The owed count saturates at OWED_MAX (default 8), and further ticks are dropped. `urgent_o` is high exactly when the count equals OWED_MAX.
- R7: After initialization, `ref_req_o` is high exactly when the owed count is non-zero. A `grant_i` pulse while `ref_req_o` is low is ignored: the count and the row are unchanged.
- R8: The row counter starts at 0 and advances by one on every accepted grant, in either mode. It wraps from ROWS-1 (2047) to 0.
- R9: `ref_ras_only_o` follows `ras_only_i`. `ref_row_o` shows the row counter when `ras_only_i` is 1 and is all zeros when it is 0 (CAS-before-RAS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_only_i | input | 1 | Refresh kind: 1 = RAS-only, 0 = CAS-before-RAS |
| grant_i | input | 1 | Sequencer accepts the pending refresh request |
| host_req_i | input | 1 | Host access request |
| ref_req_o | output | 1 | A refresh cycle is wanted |
| ref_ras_only_o | output | 1 | Kind of the requested refresh |
| ref_row_o | output | $clog2(ROWS) | Row for a RAS-only refresh, zero otherwise |
| owed_o | output | $clog2(OWED_MAX+1) | Refreshes owed but not yet granted |
| urgent_o | output | 1 | Owed count is at its limit |
| init_done_o | output | 1 | Initialization burst completed |
| host_gnt_o | output | 1 | Host request admitted |

## Verification
Some properties are checked by assertions on every cycle. These are: the run phase never ends once reached; an increment never takes a full counter past its limit; a lone grant lowers the count by one; the row steps by one (modulo ROWS) on each accepted grant and holds otherwise; and the host is never admitted before initialization. Other behaviour can only be shown by the bench's scenarios, which compare against a cycle model. This covers the exact length of the start-up hold-off, the count of initialization grants, the spacing of interval ticks, saturation after a long grant drought, the row wrap at 2047, and zero row masking in CAS-before-RAS mode.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_RUN  = 2'd2
  } ref_phase_e;

  function automatic int unsigned min_one(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction
endpackage

// File: rtl/ref_powerup_ctl.sv
module ref_powerup_ctl
  import dram_ref_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 10000,
  parameter int unsigned INIT_REFS   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  output ref_phase_e phase_o
);
  localparam int unsigned WAIT_W = $clog2(STARTUP_CYC + 1);
  localparam int unsigned INIT_W = $clog2(INIT_REFS + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(STARTUP_CYC - 1);
  localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_REFS - 1);

  ref_phase_e        phase_q;
  logic [WAIT_W-1:0] wait_q;
  logic [INIT_W-1:0] init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT;
      wait_q  <= '0;
      init_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_WAIT: begin
          if (wait_q == WAIT_LAST) phase_q <= PH_INIT;
          else                     wait_q  <= wait_q + 1'b1;
        end
        PH_INIT: begin
          if (accept_i) begin
            if (init_q == INIT_LAST) phase_q <= PH_RUN;
            init_q <= init_q + 1'b1;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign phase_o = phase_q;

  // R2
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN) |=> (phase_q == PH_RUN));
endmodule

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(INTERVAL_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INTERVAL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_owed_ctr.sv
module ref_owed_ctr #(
  parameter int unsigned OWED_MAX = 8,
  localparam int unsigned OW = $clog2(OWED_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [OW-1:0] owed_o,
  output logic          pend_o,
  output logic          urgent_o
);
  localparam logic [OW-1:0] FULL = OW'(OWED_MAX);

  logic [OW-1:0] owed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owed_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (owed_q != FULL) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0)   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign owed_o   = owed_q;
  assign pend_o   = (owed_q != '0);
  assign urgent_o = (owed_q == FULL);

  // R6
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_o && inc_i && !dec_i) |=> (owed_q == FULL));
  // R5
  grant_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && pend_o) |=> (owed_q == $past(owed_q) - 1'b1));
endmodule

// File: rtl/ref_row_ctr.sv
module ref_row_ctr #(
  parameter int unsigned ROWS = 2048,
  localparam int unsigned RW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [RW-1:0] row_o
);
  logic [RW-1:0] row_q;
  logic [RW-1:0] row_nxt;

  generate
    if (ROWS == (1 << RW)) begin : g_pow2
      assign row_nxt = row_q + 1'b1;
    end else begin : g_wrap
      assign row_nxt = (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_nxt;
  end

  assign row_o = row_q;

  // R8
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (row_q == (($past(row_q) == RW'(ROWS - 1)) ? '0 : $past(row_q) + 1'b1)));
  // R7
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 50,
  parameter int unsigned STARTUP_US   = 200,
  parameter int unsigned RETENTION_US = 32000,
  parameter int unsigned ROWS         = 2048,
  parameter int unsigned INIT_REFS    = 8,
  parameter int unsigned OWED_MAX     = 8,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned OWED_W = $clog2(OWED_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_only_i,
  input  logic              grant_i,
  input  logic              host_req_i,
  output logic              ref_req_o,
  output logic              ref_ras_only_o,
  output logic [ROW_W-1:0]  ref_row_o,
  output logic [OWED_W-1:0] owed_o,
  output logic              urgent_o,
  output logic              init_done_o,
  output logic              host_gnt_o
);
  localparam int unsigned STARTUP_CYC  = min_one(STARTUP_US * CLK_MHZ);
  localparam int unsigned INTERVAL_CYC = min_one((RETENTION_US * CLK_MHZ) / ROWS);

  ref_phase_e       phase;
  logic             run;
  logic             tick;
  logic             pend;
  logic             accept;
  logic [ROW_W-1:0] row;

  assign run       = (phase == PH_RUN);
  assign ref_req_o = (phase == PH_INIT) || (run && pend);
  assign accept    = grant_i && ref_req_o;

  ref_powerup_ctl #(.STARTUP_CYC(STARTUP_CYC), .INIT_REFS(INIT_REFS)) u_pwr (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .phase_o(phase));

  ref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick));

  ref_owed_ctr #(.OWED_MAX(OWED_MAX)) u_owed (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(tick), .dec_i(accept && run),
    .owed_o(owed_o), .pend_o(pend), .urgent_o(urgent_o));

  ref_row_ctr #(.ROWS(ROWS)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(accept), .row_o(row));

  assign init_done_o    = run;
  assign host_gnt_o     = host_req_i && run;
  assign ref_ras_only_o = ras_only_i;
  assign ref_row_o      = ras_only_i ? row : '0;

  // R3
  host_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_gnt_o |-> init_done_o);
  // R1
  startup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_o && !ref_req_o |=> !init_done_o);
endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int ST = 200;   // 4 us at 50 MHz
  localparam int IV = 15;    // 640*50/2048
  localparam int NR = 2048;
  localparam int OM = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_only_i = 1'b0, grant_i = 1'b0, host_req_i = 1'b0;
  logic ref_req_o, ref_ras_only_o, urgent_o, init_done_o, host_gnt_o;
  logic [10:0] ref_row_o;
  logic [3:0]  owed_o;

  dram_refresh_seq #(.CLK_MHZ(50), .STARTUP_US(4), .RETENTION_US(640)) dut (
    .clk_i, .rst_ni, .ras_only_i, .grant_i, .host_req_i, .ref_req_o,
    .ref_ras_only_o, .ref_row_o, .owed_o, .urgent_o, .init_done_o, .host_gnt_o);

  always #10 clk_i = ~clk_i;

  int total = 0, bad = 0, cyc = 0;
  int m_ph = 0, m_wcnt = 0, m_icnt = 0, m_tcnt = 0, m_owed = 0, m_row = 0, m_acc = 0;
  bit done = 0;

  function automatic bit exp_req(int ph, int owed);
    return (ph == 1) || (ph == 2 && owed != 0);
  endfunction
  function automatic int exp_row(bit ras, int row);
    return ras ? row : 0;
  endfunction

  // reference model from the requirements
  always @(posedge clk_i) if (rst_ni) begin
    bit acc, tick;
    cyc++;
    acc = grant_i && exp_req(m_ph, m_owed);
    if (acc) m_acc++;
    case (m_ph)
      0: if (m_wcnt == ST - 1) m_ph = 1; else m_wcnt++;
      1: if (acc) begin if (m_icnt == 7) m_ph = 2; m_icnt++; end
      default: begin
        tick = (m_tcnt == IV - 1);
        m_tcnt = tick ? 0 : m_tcnt + 1;
        if (tick && !acc && m_owed < OM) m_owed++;
        else if (!tick && acc) m_owed--;
      end
    endcase
    if (acc) m_row = (m_row + 1) % NR;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic cmp_all();
    chk("R1/R2/R7 ref_req", ref_req_o, exp_req(m_ph, m_owed));
    chk("R2 init_done", init_done_o, m_ph == 2);
    chk("R3 host_gnt", host_gnt_o, host_req_i && m_ph == 2);
    chk("R4/R5 owed", owed_o, m_owed);
    chk("R6 urgent", urgent_o, m_owed == OM);
    chk("R8/R9 ref_row", ref_row_o, exp_row(ras_only_i, m_row));
    chk("R9 ref_ras_only", ref_ras_only_o, ras_only_i);
  endtask

  bit req_seen = 0, done_seen = 0, owed_seen = 0, wrap_seen = 0;
  int done_cyc = 0, prev_row = 0;

  task automatic step(int gprob, int rprob);
    @(negedge clk_i);
    cmp_all();
    if (!req_seen && ref_req_o) begin
      req_seen = 1;
      chk("R1 first request edge", cyc, ST);
    end
    if (!done_seen && init_done_o) begin
      done_seen = 1; done_cyc = cyc;
      chk("R2 grants before init_done", m_acc, 8);
    end
    if (done_seen && !owed_seen && owed_o == 1) begin
      owed_seen = 1;
      chk("R4 first tick spacing", cyc - done_cyc, IV);
    end
    if (ras_only_i && prev_row == NR - 1 && ref_row_o == 0) wrap_seen = 1;
    prev_row = ras_only_i ? int'(ref_row_o) : -1;
    grant_i    = ($urandom_range(99) < gprob);
    ras_only_i = ($urandom_range(99) < rprob);
    host_req_i = $urandom_range(1);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    chk("R1 reset req", ref_req_o, 0);
    chk("R2 reset init_done", init_done_o, 0);
    chk("R6 reset owed", owed_o, 0);
    rst_ni = 1'b1;
    while (!done_seen) step(50, 50);
    repeat (40 * IV) step(8, 50);
    repeat (12 * IV) step(0, 50);
    chk("R6 saturated owed", owed_o, OM);
    chk("R6 saturated urgent", urgent_o, 1);
    repeat (3 * IV) step(0, 0);
    chk("R6 drop extra ticks", owed_o, OM);
    repeat (32000) step(100, 100);
    chk("R8 row wrap 2047->0 seen", wrap_seen, 1);
    repeat (3000) step(30, 50);
    chk("R4 tick observed", owed_seen, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule